// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets synchronous on-chip logic read and write an external asynchronous static RAM of 256K words by 16 bits. The user side takes one request at a time: an 18-bit word address, a read/write flag, 16 bits of write data and one active-high enable per byte lane. The block answers with a one-cycle response pulse. On a read, that pulse carries the returned data. While an access is running, the request-ready output is low.

On the memory side the block drives the address, an active-low chip select, an active-low output enable, an active-low write strobe and one active-low strobe per byte lane. It also drives the outgoing data word and the enable for the bidirectional data bus; the pad cells sit outside the block. Every access is a fixed sequence of phases. The length of each phase in clock cycles is worked out at elaboration from a clock-period parameter and nanosecond timing parameters, rounded up. Between accesses the chip select stays high, so the memory sits in standby. After a read, the block waits out the memory's output float time before it can start the next access, so the two sides never drive the bus at once.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n, mem_we_n and both mem_bs_n bits are 1, mem_dq_oe and rsp_valid are 0, and req_ready is 1.
- R2: A request is accepted at a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access, including any turnaround, is complete.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly N_ACC cycles, where N_ACC = max(ceil(T_ACC_NS/Tclk), ceil(T_RC_NS/Tclk)) (14 at the defaults). mem_dq_in is captured at the edge that ends this phase, and it appears on rsp_rdata in the cycle where rsp_valid is 1.
- R4: A write holds mem_ce_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1, with mem_dq_out equal to req_wdata, for N_WP = max(ceil(T_WP_NS/Tclk), ceil(T_DS_NS/Tclk)) cycles (10 at the defaults). mem_dq_oe falls on the same edge where mem_we_n rises.
- R5: After the write pulse, mem_ce_n stays 0 with mem_we_n=1 for max(ceil(T_WC_NS/Tclk) - N_WP, 1) cycles (4 at the defaults). Then mem_ce_n rises, and in that same cycle rsp_valid=1, req_ready=1, and rsp_rdata keeps its previous value.
- R6: After a read, mem_ce_n and mem_oe_n are 1 and req_ready is 0 for N_FLT = ceil(T_FLOAT_NS/Tclk) cycles (5 at the defaults). The read's rsp_valid pulse falls in the first of these cycles.
- R7: For the whole access, mem_bs_n[0] (data bits 7:0) equals the inverse of req_be[0] and mem_bs_n[1] (bits 15:8) equals the inverse of req_be[1]. Both are 1 whenever mem_ce_n is 1.
- R8: mem_oe_n and mem_we_n are never 0 together. mem_dq_oe is 1 only while mem_ce_n=0, mem_we_n=0 and mem_oe_n=1.
- R9: mem_addr equals the accepted req_addr and stays unchanged while mem_ce_n is 0.
- R10: req_valid while req_ready is 0 is ignored: it starts no access and changes neither the pins nor the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data of the last read |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bs_n | output | 2 | Byte-lane strobes, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Data-bus drive enable |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The assertions check the pin rules on every cycle:
- output enable and write strobe are never low together;
- bus drive happens only inside a write pulse, and its release coincides with the write strobe rising;
- the address is steady while selected, and the strobes are idle during standby;
- every read window and write pulse has its exact computed length;
- at least the float time separates a read's output-enable release from the next drive.

Only the bench scenarios can show the rest: that the data returned for each byte-enable mix matches what earlier partial writes left in memory, that a request raised while busy really leaves memory untouched, and that back-to-back operations in both orders produce the expected phase sequence.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_TURN   = 3'd2,
    PH_WPULSE = 3'd3,
    PH_WREC   = 3'd4
  } phase_e;

  // Cycles needed to cover t_ns at a clock period of clk_ps, rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles left after the pulse to fill the whole write cycle, at least one.
  function automatic int unsigned rest_cyc(input int unsigned total, input int unsigned used);
    return (total > used) ? (total - used) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_port_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned N_ACC  = 14,
  parameter int unsigned N_WP   = 10,
  parameter int unsigned N_WREC = 4,
  parameter int unsigned N_FLT  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             acc_start,
  output logic             rd_end,
  output logic             wr_end,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             ready,
  output logic             rsp_valid
);
  phase_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PH_IDLE:   if (req_valid) nxt = req_write ? PH_WPULSE : PH_READ;
      PH_READ:   if (tmr_zero)  nxt = PH_TURN;
      PH_TURN:   if (tmr_zero)  nxt = PH_IDLE;
      PH_WPULSE: if (tmr_zero)  nxt = PH_WREC;
      PH_WREC:   if (tmr_zero)  nxt = PH_IDLE;
      default:                  nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      PH_READ:   tmr_val = CNT_W'(N_ACC - 1);
      PH_TURN:   tmr_val = CNT_W'(N_FLT - 1);
      PH_WPULSE: tmr_val = CNT_W'(N_WP - 1);
      PH_WREC:   tmr_val = CNT_W'(N_WREC - 1);
      default:   tmr_val = '0;
    endcase
  end

  assign tmr_load  = (nxt != state);
  assign acc_start = (state == PH_IDLE) && (nxt != PH_IDLE);
  assign rd_end    = (state == PH_READ) && (nxt == PH_TURN);
  assign wr_end    = (state == PH_WREC) && (nxt == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      ready     <= 1'b1;
      rsp_valid <= 1'b0;
    end else begin
      state     <= nxt;
      ce_n      <= !(nxt == PH_READ || nxt == PH_WPULSE || nxt == PH_WREC);
      oe_n      <= !(nxt == PH_READ);
      we_n      <= !(nxt == PH_WPULSE);
      dq_oe     <= (nxt == PH_WPULSE);
      ready     <= (nxt == PH_IDLE);
      rsp_valid <= rd_end || wr_end;
    end
  end
endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              rd_end,
  input  logic              wr_end,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  bs_n,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mem_addr <= '0;
    else if (acc_start) mem_addr <= req_addr;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bs_n[g]            <= 1'b1;
        dq_out[g*8 +: 8]    <= '0;
        rsp_rdata[g*8 +: 8] <= '0;
      end else begin
        if (acc_start) begin
          bs_n[g]         <= !req_be[g];
          dq_out[g*8 +: 8] <= req_wdata[g*8 +: 8];
        end else if (rd_end || wr_end) begin
          bs_n[g] <= 1'b1;
        end
        if (rd_end) rsp_rdata[g*8 +: 8] <= dq_in[g*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CLK_PS     = 5000,
  parameter int unsigned T_RC_NS    = 70,
  parameter int unsigned T_ACC_NS   = 70,
  parameter int unsigned T_WC_NS    = 70,
  parameter int unsigned T_WP_NS    = 50,
  parameter int unsigned T_DS_NS    = 30,
  parameter int unsigned T_FLOAT_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W/8-1:0] mem_bs_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned N_ACC   = max2(ns_to_cyc(T_ACC_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS));
  localparam int unsigned N_WP    = max2(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_DS_NS, CLK_PS));
  localparam int unsigned N_WREC  = rest_cyc(ns_to_cyc(T_WC_NS, CLK_PS), N_WP);
  localparam int unsigned N_FLT   = ns_to_cyc(T_FLOAT_NS, CLK_PS);
  localparam int unsigned CNT_MAX = max2(max2(N_ACC, N_WP), max2(N_WREC, N_FLT));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  // Named internal events, also seen by the bound checker.
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             acc_start, rd_end, wr_end;

  sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_seq_fsm #(
    .CNT_W(CNT_W), .N_ACC(N_ACC), .N_WP(N_WP), .N_WREC(N_WREC), .N_FLT(N_FLT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .acc_start(acc_start), .rd_end(rd_end), .wr_end(wr_end),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe),
    .ready(req_ready), .rsp_valid(rsp_valid)
  );

  sram_lane_path #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lane (
    .clk(clk), .rst_n(rst_n),
    .acc_start(acc_start), .rd_end(rd_end), .wr_end(wr_end),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .dq_in(mem_dq_in),
    .mem_addr(mem_addr), .bs_n(mem_bs_n), .dq_out(mem_dq_out), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk
  import sram_port_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned LANES      = 2,
  parameter int unsigned CLK_PS     = 5000,
  parameter int unsigned T_RC_NS    = 70,
  parameter int unsigned T_ACC_NS   = 70,
  parameter int unsigned T_WP_NS    = 50,
  parameter int unsigned T_DS_NS    = 30,
  parameter int unsigned T_FLOAT_NS = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic              ready,
  input logic              rsp_valid,
  input logic              acc_start,
  input logic [LANES-1:0]  bs_n,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [15:0] C_ACC = 16'(max2(ns_to_cyc(T_ACC_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS)));
  localparam logic [15:0] C_WP  = 16'(max2(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_DS_NS, CLK_PS)));
  localparam logic [15:0] C_FLT = 16'(ns_to_cyc(T_FLOAT_NS, CLK_PS));

  logic [15:0] oe_run, we_run, gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run <= '0;
      we_run <= '0;
      gap    <= 16'hFFFF;
    end else begin
      oe_run <= oe_n ? 16'd0 : oe_run + 16'd1;
      we_run <= we_n ? 16'd0 : we_run + 16'd1;
      if (!oe_n)               gap <= '0;
      else if (gap != 16'hFFFF) gap <= gap + 16'd1;
    end
  end

  // R8
  no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  // R8
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce_n && !we_n && oe_n));
  // R4
  drive_off_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> $rose(we_n));
  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run == C_WP));
  // R3
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (oe_run == C_ACC));
  // R6
  float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (gap >= C_FLT));
  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !ready);
  // R2
  idle_means_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ce_n);
  // R7
  strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (&bs_n));
  // R9
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sram_port_ctrl sram_port_chk #(
  .ADDR_W(ADDR_W), .LANES(DATA_W / 8), .CLK_PS(CLK_PS), .T_RC_NS(T_RC_NS),
  .T_ACC_NS(T_ACC_NS), .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS), .T_FLOAT_NS(T_FLOAT_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
  .dq_oe(mem_dq_oe), .ready(req_ready), .rsp_valid(rsp_valid), .acc_start(acc_start),
  .bs_n(mem_bs_n), .addr(mem_addr)
);

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/1ps
module sim_sram_port_ctrl;
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  localparam int TCLK_PS = 5000;
  localparam int E_ACC  = (cdiv(70000, TCLK_PS) > cdiv(70000, TCLK_PS)) ? cdiv(70000, TCLK_PS) : cdiv(70000, TCLK_PS);
  localparam int E_WP   = (cdiv(50000, TCLK_PS) > cdiv(30000, TCLK_PS)) ? cdiv(50000, TCLK_PS) : cdiv(30000, TCLK_PS);
  localparam int E_WREC = (cdiv(70000, TCLK_PS) > E_WP) ? cdiv(70000, TCLK_PS) - E_WP : 1;
  localparam int E_FLT  = cdiv(25000, TCLK_PS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;
  logic [1:0]  mem_bs_n;

  always #2.5 clk = ~clk;

  sram_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory: written by the pins, read data lags the address by one clock.
  logic [15:0] store [int];
  logic [15:0] rd_word = '0;
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 16'h0;
      if (!mem_bs_n[0]) w[7:0]  = mem_dq_out[7:0];
      if (!mem_bs_n[1]) w[15:8] = mem_dq_out[15:8];
      store[int'(mem_addr)] = w;
    end
    rd_word <= store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 16'h0;
  end
  wire mem_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = {(mem_drives && !mem_bs_n[1]) ? rd_word[15:8] : 8'h00,
                      (mem_drives && !mem_bs_n[0]) ? rd_word[7:0]  : 8'h00};

  // Reference model: queue of expected pin states, one entry per clock.
  typedef struct packed {
    logic ce_n, oe_n, we_n, dq_oe, ready, rsp;
    logic [17:0] addr;
    logic [1:0]  bs_n;
    logic [15:0] wd, rd;
    logic [2:0]  ph;
  } exp_t;
  exp_t q[$];
  logic [15:0] shadow [int];
  logic [15:0] last_rd = '0;
  int tests = 0, fails = 0;
  logic in_ign = 1'b0, done = 1'b0;

  function automatic string tag_of(input logic [2:0] ph);
    case (ph)
      3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R2";
    endcase
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e = '0;
    e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.ready = 1; e.bs_n = 2'b11;
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1 reset state
      chk("R1", "reset pins", {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe},
          {26'd0, 5'b11111, 1'b0});
      chk("R1", "reset ready/rsp", {30'd0, req_ready, rsp_valid}, 32'd2);
    end else begin
      exp_t e;
      string t;
      e = (q.size() > 0) ? q.pop_front() : idle_e();
      t = in_ign ? "R10" : tag_of(e.ph);
      chk(t, "ce_n/oe_n/we_n", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, {29'd0, e.ce_n, e.oe_n, e.we_n});
      chk(t, "dq_oe", {31'd0, mem_dq_oe}, {31'd0, e.dq_oe});
      chk(in_ign ? "R10" : "R2", "ready", {31'd0, req_ready}, {31'd0, e.ready});
      chk(t, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e.rsp});
      chk(in_ign ? "R10" : "R7", "bs_n", {30'd0, mem_bs_n}, {30'd0, e.bs_n});
      if (!e.ce_n) chk("R9", "addr", {14'd0, mem_addr}, {14'd0, e.addr});
      if (e.dq_oe) chk("R4", "dq_out", {16'd0, mem_dq_out}, {16'd0, e.wd});
      if (e.rsp) chk(t, "rsp_rdata", {16'd0, rsp_rdata}, {16'd0, e.rd});
      // R8 bus ownership
      chk("R8", "oe/we overlap", {31'd0, !mem_oe_n && !mem_we_n}, 32'd0);
      chk("R8", "bus contention", {31'd0, mem_dq_oe && mem_drives}, 32'd0);
    end
  end

  task automatic op(input logic wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    exp_t e;
    logic [15:0] old, exp_rd;
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    if (wr) begin
      for (int i = 0; i < E_WP; i++) begin
        e = idle_e(); e.ce_n = 0; e.we_n = 0; e.dq_oe = 1; e.ready = 0;
        e.addr = a; e.bs_n = ~be; e.wd = d; e.ph = 3'd3; q.push_back(e);
      end
      for (int i = 0; i < E_WREC; i++) begin
        e = idle_e(); e.ce_n = 0; e.ready = 0; e.addr = a; e.bs_n = ~be; e.ph = 3'd4; q.push_back(e);
      end
      e = idle_e(); e.rsp = 1; e.rd = last_rd; e.ph = 3'd4; q.push_back(e);
      if (be[0]) old[7:0]  = d[7:0];
      if (be[1]) old[15:8] = d[15:8];
      shadow[int'(a)] = old;
    end else begin
      exp_rd = {be[1] ? old[15:8] : 8'h00, be[0] ? old[7:0] : 8'h00};
      for (int i = 0; i < E_ACC; i++) begin
        e = idle_e(); e.ce_n = 0; e.oe_n = 0; e.ready = 0; e.addr = a; e.bs_n = ~be; e.ph = 3'd1;
        q.push_back(e);
      end
      for (int i = 0; i < E_FLT; i++) begin
        e = idle_e(); e.ready = 0; e.rsp = (i == 0); e.rd = exp_rd; e.ph = 3'd2; q.push_back(e);
      end
      last_rd = exp_rd;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3 read of unwritten word returns zero
    op(0, 18'h00010, 16'h0, 2'b11);
    // R4 R5 full write, then read back
    op(1, 18'h00010, 16'hA55A, 2'b11);
    op(0, 18'h00010, 16'h0, 2'b11);
    // R7 lower lane only, then upper lane only
    op(1, 18'h00010, 16'h1234, 2'b01);
    op(0, 18'h00010, 16'h0, 2'b11);
    op(1, 18'h3FFFF, 16'hBEEF, 2'b10);
    op(0, 18'h3FFFF, 16'h0, 2'b11);
    op(0, 18'h00010, 16'h0, 2'b01);
    op(0, 18'h00010, 16'h0, 2'b10);
    // R7 write with no lane enabled changes nothing
    op(1, 18'h00010, 16'hFFFF, 2'b00);
    op(0, 18'h00010, 16'h0, 2'b11);
    // R6 read followed at once by a write, then write followed by read
    op(0, 18'h3FFFF, 16'h0, 2'b11);
    op(1, 18'h00020, 16'h0F0F, 2'b11);
    op(0, 18'h00020, 16'h0, 2'b11);
    // R10 requests while busy are ignored
    in_ign = 1;
    op(0, 18'h00020, 16'h0, 2'b11);
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = 18'h00030; req_wdata = 16'hDEAD; req_be = 2'b11;
    repeat (5) @(negedge clk);
    #1 req_valid = 0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    in_ign = 0;
    op(0, 18'h00030, 16'h0, 2'b11);
    // mixed traffic
    for (int k = 0; k < 24; k++) begin
      logic [17:0] a;
      a = 18'((k * 7) % 5) << 3;
      op(k[0], a, 16'(k * 16'h1357 + 3), 2'((k % 3) + 1));
    end
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule